// File: doc/BRIEF.md
# Single-Cycle Register Transfer Datapath

This block is the storage and steering part of a simple processor datapath. It holds a small bank of general-purpose registers and, under one control word, reads two operands, hands them to a function unit that sits outside the block, and writes a result back to a chosen register. The read, the operation and the write-back all complete on a single rising clock edge.

The A operand comes straight from the register picked by the A-side select. The B operand is either a register, picked by its own select, or a constant supplied on an input port. The value to be written is taken either from the result the function unit returns or from an external data input. A destination select and a write enable decide which register, if any, captures that value. Register reads are combinational. A register that is written in a cycle therefore shows its old contents on the operand buses until the edge. A transfer such as "register 1 gets register 2 plus register 3" is one control word held for one cycle.

Top module: `regdp_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register becomes 0 on that edge. This holds even if `wr_en` is high in the same cycle.
- R2: `fu_a` always equals the register whose index is on `a_sel`.
- R3: When `b_const` is 0, `fu_b` equals the register whose index is on `b_sel`. When `b_const` is 1, `fu_b` equals `const_in`.
- R4: When `d_ext` is 0, `d_bus` equals `fu_result`. When `d_ext` is 1, `d_bus` equals `ext_data`.
- R5: At a rising edge with `rst_n` high and `wr_en` at 1, the register with index `dst_sel` takes the value on `d_bus`. Every other register keeps its value.
- R6: At a rising edge with `rst_n` high and `wr_en` at 0, no register changes.
- R7: A register being written in the current cycle shows its old value on `fu_a` and `fu_b` until the edge. It shows the new value from the edge onward.
- R8: A full transfer completes in one cycle. Examples are a destination getting the sum of two registers, and a destination getting a register plus a constant. The sum wraps modulo 256, and the result can be read on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel | input | 2 | Register index driven onto the A operand |
| b_sel | input | 2 | Register index for the B operand |
| b_const | input | 1 | 1 selects `const_in` for the B operand |
| const_in | input | 8 | Constant operand |
| fu_a | output | 8 | A operand to the function unit |
| fu_b | output | 8 | B operand to the function unit |
| fu_result | input | 8 | Result returned by the function unit |
| d_ext | input | 1 | 1 selects `ext_data` as the write-back value |
| ext_data | input | 8 | External data for write-back |
| dst_sel | input | 2 | Destination register index |
| wr_en | input | 1 | Write enable for the destination |
| d_bus | output | 8 | Write-back value |

## Verification
The bench goes after reads and writes that hit the same register in one cycle. A design with a write-through bypass would show the new value too early, and that breaks R7. It drives reset with the write enable high. A design that gives the write priority would leave a non-zero register behind. It also checks that a write lands only in its destination. Faulty index decoding would corrupt a neighbour or drop the write. Finally it runs sums that overflow eight bits, together with long random control sequences. Wrong selection on the B or write-back path would then show up as a wrong operand or a wrong register value.

// File: rtl/regdp_pkg.sv
// Shared defaults and source encodings for the register transfer datapath.
// Assumes: one-bit source selects, 0 = internal path, 1 = external input.
package regdp_pkg;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_NREG  = 4;

    typedef enum logic {
        BSRC_REG   = 1'b0,
        BSRC_CONST = 1'b1
    } bsrc_e;

    typedef enum logic {
        DSRC_FU  = 1'b0,
        DSRC_EXT = 1'b1
    } dsrc_e;
endpackage

// File: rtl/regdp_mux2.sv
// Two-input word multiplexer used on the B operand and write-back paths.
// Assumes: sel is a known value; 0 passes in0, 1 passes in1.
module regdp_mux2 #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    output logic [W-1:0] y
);
    // Purpose: pick one word according to sel.
    always_comb begin
        y = sel ? in1 : in0;
    end
endmodule

// File: rtl/regdp_regfile.sv
// Register bank with NRD combinational read ports and one synchronous write port.
// Assumes: reset is synchronous and active low, and it wins over a write.
module regdp_regfile #(
    parameter int W     = 8,
    parameter int N     = 4,
    parameter int NRD   = 2,
    parameter int SEL_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          wsel,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][SEL_W-1:0] rsel,
    output logic [NRD-1:0][W-1:0]     rdata
);
    logic [N-1:0][W-1:0] regs;

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Purpose: clear on reset, otherwise capture wdata when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (wsel == SEL_W'(i))) begin
                regs[i] <= wdata;
            end
        end

        AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!we || wsel != SEL_W'(i)) |=> $stable(regs[i])); // R6
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Purpose: combinational read, no bypass of the pending write.
        always_comb begin
            rdata[p] = regs[rsel[p]];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (regs == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wsel)] == $past(wdata))); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs)); // R6
endmodule

// File: rtl/regdp_core.sv
// Single-cycle datapath: register bank, B operand select and write-back select.
// Assumes: the function unit outside is purely combinational from fu_a/fu_b to fu_result.
module regdp_core
    import regdp_pkg::*;
#(
    parameter int W     = DEF_WIDTH,
    parameter int N     = DEF_NREG,
    parameter int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] a_sel,
    input  logic [SEL_W-1:0] b_sel,
    input  logic             b_const,
    input  logic [W-1:0]     const_in,
    output logic [W-1:0]     fu_a,
    output logic [W-1:0]     fu_b,
    input  logic [W-1:0]     fu_result,
    input  logic             d_ext,
    input  logic [W-1:0]     ext_data,
    input  logic [SEL_W-1:0] dst_sel,
    input  logic             wr_en,
    output logic [W-1:0]     d_bus
);
    localparam int NRD = 2;

    logic [NRD-1:0][SEL_W-1:0] rd_sel;
    logic [NRD-1:0][W-1:0]     rd_word;
    bsrc_e                     b_src;
    dsrc_e                     d_src;

    // Purpose: gather read indices and decode the source selects.
    always_comb begin
        rd_sel[0] = a_sel;
        rd_sel[1] = b_sel;
        b_src     = bsrc_e'(b_const);
        d_src     = dsrc_e'(d_ext);
    end

    regdp_regfile #(.W(W), .N(N), .NRD(NRD), .SEL_W(SEL_W)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wsel  (dst_sel),
        .wdata (d_bus),
        .rsel  (rd_sel),
        .rdata (rd_word)
    );

    assign fu_a = rd_word[0];

    regdp_mux2 #(.W(W)) i_bmux (
        .sel (b_src == BSRC_CONST),
        .in0 (rd_word[1]),
        .in1 (const_in),
        .y   (fu_b)
    );

    regdp_mux2 #(.W(W)) i_dmux (
        .sel (d_src == DSRC_EXT),
        .in0 (fu_result),
        .in1 (ext_data),
        .y   (d_bus)
    );

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dst_sel == a_sel) ##1 (a_sel == $past(a_sel))
        |-> (fu_a == $past(d_bus))); // R7
endmodule

// File: tb/test_regdp_core.sv
// Bench: behavioural register model and reference function unit, compared every cycle.
module test_regdp_core;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] a_sel, b_sel, dst_sel;
    logic       b_const, d_ext, wr_en;
    logic [7:0] const_in, ext_data, fu_result;
    logic [7:0] fu_a, fu_b, d_bus;
    logic [1:0] fu_op;

    logic [7:0] mdl [4];
    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    // Reference function unit: 0 add, 1 subtract, 2 xor, 3 pass A.
    always_comb begin
        case (fu_op)
            2'd0:    fu_result = fu_a + fu_b;
            2'd1:    fu_result = fu_a - fu_b;
            2'd2:    fu_result = fu_a ^ fu_b;
            default: fu_result = fu_a;
        endcase
    end

    regdp_core i_regdp_core (
        .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel),
        .b_const(b_const), .const_in(const_in), .fu_a(fu_a), .fu_b(fu_b),
        .fu_result(fu_result), .d_ext(d_ext), .ext_data(ext_data),
        .dst_sel(dst_sel), .wr_en(wr_en), .d_bus(d_bus)
    );

    function automatic logic [7:0] ref_fu(logic [1:0] op, logic [7:0] a, logic [7:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a ^ b;
            default: return a;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive a control word, check buses before the edge, update model after.
    task automatic step(logic rst, logic [1:0] as, logic [1:0] bs, logic bc,
                        logic [7:0] k, logic de, logic [7:0] ex, logic [1:0] ds,
                        logic we, logic [1:0] op);
        logic [7:0] ea, eb, ed;
        @(negedge clk);
        rst_n = rst; a_sel = as; b_sel = bs; b_const = bc; const_in = k;
        d_ext = de; ext_data = ex; dst_sel = ds; wr_en = we; fu_op = op;
        #1;
        ea = mdl[as];
        eb = bc ? k : mdl[bs];
        ed = de ? ex : ref_fu(op, ea, eb);
        if (rst) begin
            chk("R2", fu_a, ea);
            chk("R3", fu_b, eb);
            chk("R4", d_bus, ed);
        end
        @(posedge clk);
        if (!rst) begin
            for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        end else if (we) begin
            mdl[ds] = ed;
        end
    endtask

    // Read two registers through the operand buses and compare with the model.
    task automatic peek(string req, logic [1:0] r0, logic [1:0] r1, logic [7:0] e0, logic [7:0] e1);
        @(negedge clk);
        rst_n = 1'b1; a_sel = r0; b_sel = r1; b_const = 1'b0; wr_en = 1'b0; d_ext = 1'b0;
        #1;
        chk(req, fu_a, e0);
        chk(req, fu_b, e1);
        chk(req, fu_a, mdl[r0]);
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 8'hxx;
        rst_n = 1'b0; a_sel = 0; b_sel = 0; b_const = 0; const_in = 0;
        d_ext = 0; ext_data = 0; dst_sel = 0; wr_en = 0; fu_op = 0;
        // R1: reset with write enabled still clears everything.
        step(1'b0, 0, 0, 0, 8'h00, 1, 8'hAA, 2'd1, 1, 0);
        step(1'b0, 0, 0, 0, 8'h00, 1, 8'h55, 2'd2, 1, 0);
        peek("R1", 2'd0, 2'd1, 8'h00, 8'h00);
        peek("R1", 2'd2, 2'd3, 8'h00, 8'h00);

        // R5: load from external data, one destination at a time.
        step(1, 0, 0, 0, 8'h00, 1, 8'h35, 2'd2, 1, 0);
        step(1, 0, 0, 0, 8'h00, 1, 8'h4A, 2'd3, 1, 0);
        step(1, 0, 0, 0, 8'h00, 1, 8'hF0, 2'd0, 1, 0);
        peek("R5", 2'd2, 2'd3, 8'h35, 8'h4A);
        peek("R5", 2'd0, 2'd1, 8'hF0, 8'h00);

        // R8: register 1 gets register 2 plus register 3 in one cycle.
        step(1, 2'd2, 2'd3, 0, 8'h00, 0, 8'h00, 2'd1, 1, 0);
        peek("R8", 2'd1, 2'd2, 8'h7F, 8'h35);
        // R8: register 3 gets register 0 plus constant 0x20, wrapping to 0x10.
        step(1, 2'd0, 2'd0, 1, 8'h20, 0, 8'h00, 2'd3, 1, 0);
        peek("R8", 2'd3, 2'd0, 8'h10, 8'hF0);

        // R6: write enable low leaves all registers untouched.
        step(1, 2'd1, 2'd1, 0, 8'h00, 1, 8'hEE, 2'd1, 0, 0);
        peek("R6", 2'd1, 2'd3, 8'h7F, 8'h10);

        // R7: read and write register 1 in one cycle; old value before, new after.
        @(negedge clk);
        rst_n = 1; a_sel = 2'd1; b_sel = 2'd1; b_const = 0; d_ext = 1; ext_data = 8'h99;
        dst_sel = 2'd1; wr_en = 1; fu_op = 0;
        #1;
        chk("R7", fu_a, 8'h7F);
        chk("R7", fu_b, 8'h7F);
        @(posedge clk);
        mdl[1] = 8'h99;
        #1;
        chk("R7", fu_a, 8'h99);

        // R2 R3 R4 R5: random control words against the model.
        for (int n = 0; n < 400; n++) begin
            step(1'b1, 2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
                 1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom));
        end
        peek("R5", 2'd0, 2'd1, mdl[0], mdl[1]);
        peek("R5", 2'd2, 2'd3, mdl[2], mdl[3]);

        // R1: reset in mid-run.
        step(1'b0, 0, 0, 0, 8'h00, 1, 8'h77, 2'd0, 1, 0);
        peek("R1", 2'd0, 2'd3, 8'h00, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule